// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block sends one stored control bit per connection location on a single serial pin once in every frame. The pin runs at twice the bit rate of the switched data streams, so each stored bit fills two consecutive output cells. One clock period is one output cell. A frame has 512 cells that carry 256 bits. The bits go out in location order. A location number is `channel * STREAMS + stream`, which makes the bits of all streams for one channel slot leave together.

The block presents a location index on a read port and takes the stored bit back one clock later. It sends the bits for a channel one whole channel slot (16 cells) before that channel appears on the data streams. Downstream logic therefore holds the bit before the channel it describes begins. A frame pulse aligns the cell count. Between pulses the count runs freely and wraps every 512 cells.

Top module: `ctl_bit_serializer`

## Requirements
- R1: `ser_o` is 0 during reset. It stays 0 after reset until the first `frame_i` pulse, and it is also 0 in cells 0 and 1 of the first frame after that pulse.
- R2: If `frame_i` is high at clock edge E, cell n (0 to 511) of the frame is on `ser_o` during the cycle after edge E+n. Without a further pulse the next frame follows 512 cells later with the same alignment.
- R3: Cell n carries the stored bit at location `((n / 2) + 8) mod 256`.
- R4: Cells 2i and 2i+1 of a frame always carry the same value.
- R5: Cells 16k to 16k+15 carry the bits of channel `(k+1) mod 32`, streams 0 to 7 in that order. Slot 31 carries channel 0.
- R6: The bit on `rd_bit_i` in the cycle after an index is presented is the value placed on `ser_o` in the following cycle.
- R7: A `frame_i` pulse that arrives at any cell restarts the count. From cell 2 of the new frame onward, the output follows the R2/R3 alignment. In the cycle after the pulse, `rd_addr_o` is 9.
- R8: The read index goes up by one every two cells, and it wraps from 255 to 0. In the cycle after edge E+493 it reads 255, and after edge E+494 it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output cell clock, twice the stream bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame alignment pulse, one clock wide |
| rd_addr_o | output | 8 | Index of the control bit location being read |
| rd_bit_i | input | 1 | Stored bit, returned one clock after the index |
| ser_o | output | 1 | Serial control bit output |

## Verification
The assertions check on every cycle that the output stays silent until the block is armed, that each output cell equals the bit read one cycle earlier, that the read index moves by zero or one and wraps from 255 to 0, and that a frame pulse reloads the index to 9. Only the bench's scenarios can show that whole frames hold the correct bit in the correct cell. This covers the one-slot lead for each channel, matched cell pairs, free running with no pulse, and realignment after a pulse in the middle of a frame. The bench checks these against a memory model with one cycle of latency, filled with several bit patterns.

// File: rtl/ctl_bit_serializer.sv
module ctl_bit_serializer #(
  parameter int STREAMS       = 8,
  parameter int CHANNELS      = 32,
  parameter int CELLS_PER_BIT = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    frame_i,
  output logic [$clog2(STREAMS*CHANNELS)-1:0]     rd_addr_o,
  input  logic                                    rd_bit_i,
  output logic                                    ser_o
);
  localparam int LOCS    = STREAMS * CHANNELS;
  localparam int AW      = $clog2(LOCS);
  localparam int CSH     = $clog2(CELLS_PER_BIT);
  localparam int CW      = AW + CSH;
  localparam int PIPE    = 2;

  logic [CW-1:0] pos;
  logic          armed;
  logic          live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      armed <= 1'b0;
      live  <= 1'b0;
      ser_o <= 1'b0;
    end else begin
      pos   <= frame_i ? CW'(PIPE) : pos + CW'(1);
      armed <= armed | frame_i;
      live  <= armed;
      ser_o <= live & rd_bit_i;
    end
  end

  assign rd_addr_o = pos[CW-1:CSH] + AW'(STREAMS);
endmodule

// File: rtl/ctl_bit_serializer_chk.sv
module ctl_bit_serializer_chk #(
  parameter int STREAMS       = 8,
  parameter int CHANNELS      = 32,
  parameter int CELLS_PER_BIT = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                frame_i,
  input logic [$clog2(STREAMS*CHANNELS)-1:0] rd_addr_o,
  input logic                                rd_bit_i,
  input logic                                ser_o,
  input logic                                armed,
  input logic                                live
);
  localparam int LOCS = STREAMS * CHANNELS;
  localparam int AW   = $clog2(LOCS);
  localparam int CSH  = $clog2(CELLS_PER_BIT);

  p_quiet_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !ser_o);

  p_cell_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> (ser_o == $past(rd_bit_i)));

  p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> (rd_addr_o == $past(rd_addr_o) || rd_addr_o == $past(rd_addr_o) + AW'(1)));

  p_index_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_i && rd_addr_o == AW'(LOCS-1)) |=> (rd_addr_o == AW'(LOCS-1) || rd_addr_o == '0));

  p_resync_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (rd_addr_o == AW'((2 >> CSH) + STREAMS)));
endmodule

bind ctl_bit_serializer ctl_bit_serializer_chk #(
  .STREAMS(STREAMS), .CHANNELS(CHANNELS), .CELLS_PER_BIT(CELLS_PER_BIT)
) u_chk (.*);

// File: tb/sim_ctl_bit_serializer.sv
`timescale 1ns/1ps
module sim_ctl_bit_serializer;
  logic       clk;
  logic       rst_n;
  logic       frame;
  logic [7:0] rd_addr;
  logic       rd_bit;
  logic       ser;
  logic       mem  [256];
  logic       cap  [512];
  logic [7:0] acap [512];
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] VEC [6] = '{32'hA5F0_3C81, 32'h0000_0001, 32'hFFFF_FFFF,
                                      32'h8000_0000, 32'h1234_5678, 32'h6DB6_DB6D};

  ctl_bit_serializer u0 (.clk(clk), .rst_n(rst_n), .frame_i(frame),
                         .rd_addr_o(rd_addr), .rd_bit_i(rd_bit), .ser_o(ser));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_ff @(posedge clk) rd_bit <= mem[rd_addr];

  function automatic logic exp_cell(int n);
    return mem[((n >> 1) + 8) % 256];
  endfunction

  task automatic chk(string tag, logic act, logic exp, int n);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cell %0d actual=%b expected=%b", tag, n, act, exp);
    end
  endtask

  task automatic fill(int i);
    for (int a = 0; a < 256; a++) mem[a] = VEC[i][a % 32] ^ a[5 + (i % 3)];
  endtask

  task automatic run_frame(int ncells, bit pulse);
    if (pulse) frame = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame = 1'b0;
    cap[0] = ser; acap[0] = rd_addr;
    for (int k = 1; k < ncells; k++) begin
      @(negedge clk);
      cap[k] = ser; acap[k] = rd_addr;
    end
  endtask

  task automatic check_frame(string tag, int from, bit zero_head);
    for (int k = from; k < 512; k++)
      chk(tag, cap[k], (zero_head && k < 2) ? 1'b0 : exp_cell(k), k);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame = 1'b0;
    for (int a = 0; a < 256; a++) mem[a] = 1'b1;
    repeat (5) begin @(negedge clk); chk("R1 reset", ser, 1'b0, -1); end
    rst_n = 1'b1;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (k % 50 == 0) chk("R1 before pulse", ser, 1'b0, k);
    end

    // R1 first frame head silent, R2 alignment from cell 2
    fill(0);
    run_frame(512, 1'b1);
    check_frame("R1/R2 first frame", 0, 1'b1);

    // vector table walk: R3 content, R6 latency
    for (int i = 0; i < 6; i++) begin
      fill(i);
      run_frame(512, 1'b1);
      run_frame(512, 1'b1);
      check_frame("R3/R6 vector", 0, 1'b0);
      for (int p = 0; p < 256; p++)
        chk("R4 pair", cap[2*p+1], cap[2*p], 2*p+1);
    end

    // R2 free running without a pulse
    run_frame(512, 1'b0);
    check_frame("R2 free run", 0, 1'b0);

    // R5 one-slot lead, R8 wrap
    for (int a = 0; a < 256; a++) mem[a] = 1'b0;
    mem[43] = 1'b1;
    mem[0]  = 1'b1;
    run_frame(512, 1'b1);
    run_frame(512, 1'b1);
    chk("R5 slot4 ch5 st3", cap[70], 1'b1, 70);
    chk("R5 slot4 ch5 st3", cap[71], 1'b1, 71);
    chk("R5 neighbour", cap[69], 1'b0, 69);
    chk("R5 neighbour", cap[72], 1'b0, 72);
    chk("R5 slot31 ch0", cap[496], 1'b1, 496);
    chk("R5 slot31 ch0", cap[497], 1'b1, 497);
    chk("R5 neighbour", cap[495], 1'b0, 495);
    chk("R5 neighbour", cap[498], 1'b0, 498);
    chk("R8 index 255", acap[493] == 8'd255, 1'b1, 493);
    chk("R8 index 0", acap[494] == 8'd0, 1'b1, 494);

    // R7 pulse mid-frame
    fill(4);
    run_frame(512, 1'b1);
    run_frame(100, 1'b1);
    run_frame(512, 1'b1);
    chk("R7 index after pulse", acap[0] == 8'd9, 1'b1, 0);
    check_frame("R7 resync", 2, 1'b0);

    summary();
    $finish;
  end
endmodule